// File: doc/BRIEF.md
# Parallel Programming Host Sequencer

This block sits on the host side of a high-voltage parallel programming link to a small microcontroller. A front end hands it one request at a time over a valid/ready handshake: load a command byte, load an address low byte, load a data byte, read a byte back, or pulse the write strobe. A normal write uses a short pulse. A long write serves chip erase and fuse programming. The block turns each request into pin activity on the link: the XTAL1 load strobe, the two load-type select lines, the byte select line, the active-low write and output-enable lines, and an 8-bit data bus that the host drives only while it loads a byte.

Every minimum time on the link is a parameter in nanoseconds. The block rounds each one up to whole system clock cycles using the clock period parameter. After a write pulse, the block waits for the target's ready/busy line to read high, up to a timeout, before it reports completion. A built-in signature macro runs three steps in one request: a command load of 0x08, an address load of the chosen index, and a read.

Top module: `pp_host_seq`

## Requirements
- R1: After reset the link is idle: xtal1_o=0, wr_no=1, oe_no=1, data_oe_o=0, req_ready_o=1 and rsp_valid_o=0.
- R2: A load request puts the select code on xa_o, with 2'b10 for a command (op 0), 2'b00 for an address (op 1) and 2'b01 for data (op 2). It also puts req_data_i on data_o and req_bs_i on bs_o, with data_oe_o high. All of these stay unchanged for at least ceil(T_SETUP_NS/CLK_NS) cycles before XTAL1 rises and until ceil(T_HOLD_NS/CLK_NS) cycles after it falls.
- R3: Each XTAL1 high pulse lasts exactly ceil(T_XHIGH_NS/CLK_NS) cycles.
- R4: A read request (op 3) drives oe_no low for ceil(T_OE_NS/CLK_NS) cycles, with bs_o = req_bs_i. It captures data_i in the last cycle of that window and returns the byte on rsp_data_o.
- R5: The host never drives DATA (data_oe_o) while oe_no is low, nor in the cycle after oe_no returns high.
- R6: A normal write (op 4) holds wr_no low for exactly ceil(T_WR_NS/CLK_NS) cycles. Before WR falls, bs_o has been valid and XTAL1 low for at least max(ceil(T_XLWL_NS/CLK_NS), ceil(T_BVWL_NS/CLK_NS)) cycles.
- R7: A long write (op 5) holds wr_no low for exactly ceil(T_WR_LONG_NS/CLK_NS) cycles.
- R8: After WR rises, the write completes with rsp_timeout_o=0 as soon as the synchronized rdy_i is high. This includes the case where rdy_i is already high when WR rises.
- R9: If rdy_i stays low for ceil(T_TIMEOUT_NS/CLK_NS) cycles after WR rises, the write completes with rsp_timeout_o=1.
- R10: bs_o does not change while wr_no is low, nor during the ready wait that follows.
- R11: A signature request (op 6) with index req_data_i[1:0] performs, in order: a command load of 0x08 with bs_o=0, an address load of the index with bs_o=0, and a read with bs_o=0. It returns the byte read.
- R12: req_ready_o is low from acceptance until the single-cycle rsp_valid_o pulse that ends the request, and it returns high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request accepted when valid |
| req_op_i | input | 3 | Operation code (0 cmd, 1 addr, 2 data, 3 read, 4 write, 5 long write, 6 signature) |
| req_data_i | input | 8 | Byte to load, or signature index in bits 1:0 |
| req_bs_i | input | 1 | Byte select for the request (ignored by signature) |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_data_o | output | 8 | Last byte read |
| rsp_timeout_o | output | 1 | Ready wait timed out |
| xtal1_o | output | 1 | Load strobe |
| xa_o | output | 2 | Load type select |
| bs_o | output | 1 | Byte select |
| wr_no | output | 1 | Write strobe, active low |
| oe_no | output | 1 | Output enable, active low |
| data_o | output | 8 | Bus value driven by the host |
| data_oe_o | output | 1 | Host drives the bus when high |
| data_i | input | 8 | Bus value driven by the target |
| rdy_i | input | 1 | Target ready/busy, high when ready |

## Verification
On every cycle, the assertions check the bus rules: no host drive during OE low or the release cycle after it, a stable load word around each XTAL1 pulse, the minimum XTAL1 and WR pulse widths, a stable byte select during the write and its ready wait, and the front-end busy interval. Other properties can only be shown by the bench scenarios. These are the exact select codes and bytes of each load, the order of the signature macro steps, the byte returned by a read, the exact short and long write widths, and whether a write ends on ready or on timeout, each against a target model that answers the strobes.

// File: rtl/pp_host_pkg.sv
package pp_host_pkg;

  typedef enum logic [2:0] {
    OP_CMD        = 3'd0,
    OP_ADDR       = 3'd1,
    OP_DATA       = 3'd2,
    OP_READ       = 3'd3,
    OP_WRITE      = 3'd4,
    OP_WRITE_LONG = 3'd5,
    OP_SIG        = 3'd6
  } op_e;

  localparam logic [1:0] XA_CMD  = 2'b10;
  localparam logic [1:0] XA_ADDR = 2'b00;
  localparam logic [1:0] XA_DATA = 2'b01;
  localparam logic [7:0] SIG_CMD = 8'h08;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_XHI, S_HOLD, S_OE, S_REL, S_WPRE, S_WLOW, S_WWAIT, S_DONE
  } state_e;

  function automatic int ns2cyc(int ns, int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pp_seq_timer.sv
module pp_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pp_host_seq.sv
module pp_host_seq
  import pp_host_pkg::*;
#(
  parameter int CLK_NS       = 20,
  parameter int T_SETUP_NS   = 67,
  parameter int T_XHIGH_NS   = 67,
  parameter int T_HOLD_NS    = 67,
  parameter int T_XLWL_NS    = 67,
  parameter int T_BVWL_NS    = 67,
  parameter int T_WR_NS      = 67,
  parameter int T_OE_NS      = 20,
  parameter int T_REL_NS     = 20,
  parameter int T_WR_LONG_NS = 10_000_000,
  parameter int T_TIMEOUT_NS = 1_000_000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  output logic       req_ready_o,
  input  logic [2:0] req_op_i,
  input  logic [7:0] req_data_i,
  input  logic       req_bs_i,
  output logic       rsp_valid_o,
  output logic [7:0] rsp_data_o,
  output logic       rsp_timeout_o,
  output logic       xtal1_o,
  output logic [1:0] xa_o,
  output logic       bs_o,
  output logic       wr_no,
  output logic       oe_no,
  output logic [7:0] data_o,
  output logic       data_oe_o,
  input  logic [7:0] data_i,
  input  logic       rdy_i
);
  localparam int C_SETUP = ns2cyc(T_SETUP_NS, CLK_NS);
  localparam int C_XHI   = ns2cyc(T_XHIGH_NS, CLK_NS);
  localparam int C_HOLD  = imax(ns2cyc(T_HOLD_NS, CLK_NS), 1);
  localparam int C_PRE   = imax(ns2cyc(T_XLWL_NS, CLK_NS), ns2cyc(T_BVWL_NS, CLK_NS));
  localparam int C_WR    = ns2cyc(T_WR_NS, CLK_NS);
  localparam int C_LONG  = ns2cyc(T_WR_LONG_NS, CLK_NS);
  localparam int C_OE    = ns2cyc(T_OE_NS, CLK_NS);
  localparam int C_REL   = ns2cyc(T_REL_NS, CLK_NS);
  localparam int C_TO    = ns2cyc(T_TIMEOUT_NS, CLK_NS);
  localparam int C_MAX   = imax(imax(imax(C_SETUP, C_XHI), imax(C_HOLD, C_PRE)),
                                imax(imax(C_WR, C_LONG), imax(imax(C_OE, C_REL), C_TO)));
  localparam int TW      = $clog2(C_MAX + 1);

  state_e     state_q, state_d;
  op_e        op_q, op_d;
  logic [7:0] data_q, data_d, rsp_q, rsp_d;
  logic [1:0] xa_q, xa_d, idx_q, idx_d, step_q, step_d;
  logic       bs_q, bs_d, tmo_q, tmo_d;
  logic       tz, rdy_s;
  logic [TW-1:0] dur;

  pp_seq_timer #(.TW(TW)) u_timer (
    .clk_i, .rst_ni, .load_i(state_d != state_q), .val_i(dur), .zero_o(tz)
  );

  pp_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk_i, .rst_ni, .d_i(rdy_i), .q_o(rdy_s)
  );

  always_comb begin
    case (state_d)
      S_SETUP: dur = TW'(C_SETUP - 1);
      S_XHI:   dur = TW'(C_XHI - 1);
      S_HOLD:  dur = TW'(C_HOLD - 1);
      S_OE:    dur = TW'(C_OE - 1);
      S_REL:   dur = TW'(C_REL - 1);
      S_WPRE:  dur = TW'(C_PRE - 1);
      S_WLOW:  dur = (op_q == OP_WRITE_LONG) ? TW'(C_LONG - 1) : TW'(C_WR - 1);
      S_WWAIT: dur = TW'(C_TO - 1);
      default: dur = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    data_d  = data_q;
    xa_d    = xa_q;
    bs_d    = bs_q;
    idx_d   = idx_q;
    step_d  = step_q;
    rsp_d   = rsp_q;
    tmo_d   = tmo_q;
    case (state_q)
      S_IDLE: if (req_valid_i) begin
        op_d   = op_e'(req_op_i);
        data_d = req_data_i;
        bs_d   = req_bs_i;
        tmo_d  = 1'b0;
        step_d = 2'd0;
        case (op_e'(req_op_i))
          OP_CMD:  begin xa_d = XA_CMD;  state_d = S_SETUP; end
          OP_ADDR: begin xa_d = XA_ADDR; state_d = S_SETUP; end
          OP_DATA: begin xa_d = XA_DATA; state_d = S_SETUP; end
          OP_READ: state_d = S_OE;
          OP_WRITE, OP_WRITE_LONG: state_d = S_WPRE;
          OP_SIG: begin
            xa_d    = XA_CMD;
            data_d  = SIG_CMD;
            bs_d    = 1'b0;
            idx_d   = req_data_i[1:0];
            step_d  = 2'd1;
            state_d = S_SETUP;
          end
          default: state_d = S_DONE;
        endcase
      end
      S_SETUP: if (tz) state_d = S_XHI;
      S_XHI:   if (tz) state_d = S_HOLD;
      S_HOLD: if (tz) begin
        if (step_q == 2'd1) begin
          step_d  = 2'd2;
          xa_d    = XA_ADDR;
          data_d  = {6'd0, idx_q};
          state_d = S_SETUP;
        end else if (step_q == 2'd2) begin
          step_d  = 2'd0;
          state_d = S_OE;
        end else begin
          state_d = S_DONE;
        end
      end
      S_OE: if (tz) begin
        rsp_d   = data_i;
        state_d = S_REL;
      end
      S_REL:  if (tz) state_d = S_DONE;
      S_WPRE: if (tz) state_d = S_WLOW;
      S_WLOW: if (tz) state_d = S_WWAIT;
      S_WWAIT: begin
        if (rdy_s) state_d = S_DONE;
        else if (tz) begin
          tmo_d   = 1'b1;
          state_d = S_DONE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_CMD;
      data_q  <= '0;
      xa_q    <= XA_ADDR;
      bs_q    <= 1'b0;
      idx_q   <= '0;
      step_q  <= '0;
      rsp_q   <= '0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      data_q  <= data_d;
      xa_q    <= xa_d;
      bs_q    <= bs_d;
      idx_q   <= idx_d;
      step_q  <= step_d;
      rsp_q   <= rsp_d;
      tmo_q   <= tmo_d;
    end
  end

  assign req_ready_o   = (state_q == S_IDLE);
  assign rsp_valid_o   = (state_q == S_DONE);
  assign rsp_data_o    = rsp_q;
  assign rsp_timeout_o = tmo_q;
  assign xtal1_o       = (state_q == S_XHI);
  assign xa_o          = xa_q;
  assign bs_o          = bs_q;
  assign data_o        = data_q;
  assign data_oe_o     = (state_q == S_SETUP) || (state_q == S_XHI) || (state_q == S_HOLD);
  assign oe_no         = (state_q != S_OE);
  assign wr_no         = (state_q != S_WLOW);

  // checker counters
  logic [TW:0] xhi_cnt, wr_cnt;
  logic        oe_prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xhi_cnt <= '0;
      wr_cnt  <= '0;
      oe_prev <= 1'b1;
    end else begin
      xhi_cnt <= xtal1_o ? xhi_cnt + 1'b1 : '0;
      wr_cnt  <= !wr_no  ? wr_cnt + 1'b1  : '0;
      oe_prev <= oe_no;
    end
  end

  a_r5_no_drive_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_oe_o && (!oe_no || !oe_prev)));
  a_r2_load_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xtal1_o || $fell(xtal1_o)) |-> ($stable(data_o) && $stable(xa_o) && $stable(bs_o) && data_oe_o));
  a_r2_setup_before_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xtal1_o) |-> $past(data_oe_o));
  a_r3_xhigh_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(xtal1_o) |-> (xhi_cnt >= (TW+1)'(C_XHI)));
  a_r6_wr_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> (wr_cnt >= (TW+1)'(C_WR)));
  a_r6_wr_oe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!wr_no && !oe_no) && !(!wr_no && xtal1_o));
  a_r10_bs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_no || $past(!wr_no) || (state_q == S_WWAIT)) |-> $stable(bs_o));
  a_r12_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!req_ready_o && !rsp_valid_o));
  a_r12_ready_after_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (req_ready_o && !rsp_valid_o));
endmodule

// File: tb/pp_host_seq_tb_top.sv
`timescale 1ns/1ps
module pp_host_seq_tb_top;
  import pp_host_pkg::*;

  localparam int CLK_NS  = 20;
  localparam int LONG_NS = 2000;
  localparam int TO_NS   = 4000;
  localparam int E_SETUP = (67 + CLK_NS - 1) / CLK_NS;
  localparam int E_XHI   = (67 + CLK_NS - 1) / CLK_NS;
  localparam int E_WR    = (67 + CLK_NS - 1) / CLK_NS;
  localparam int E_LONG  = (LONG_NS + CLK_NS - 1) / CLK_NS;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_bs = 0;
  logic [2:0] req_op = 0;
  logic [7:0] req_data = 0;
  logic req_ready, rsp_valid, rsp_timeout, xtal1, bs, wr_n, oe_n, data_oe;
  logic [7:0] rsp_data, data_out, data_in;
  logic [1:0] xa;
  logic rdy = 1;

  always #(CLK_NS/2) clk = ~clk;

  pp_host_seq #(.CLK_NS(CLK_NS), .T_WR_LONG_NS(LONG_NS), .T_TIMEOUT_NS(TO_NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_data_i(req_data), .req_bs_i(req_bs),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_timeout_o(rsp_timeout),
    .xtal1_o(xtal1), .xa_o(xa), .bs_o(bs), .wr_no(wr_n), .oe_no(oe_n),
    .data_o(data_out), .data_oe_o(data_oe), .data_i(data_in), .rdy_i(rdy)
  );

  int tests = 0, fails = 0, rsp_seen = 0, viol = 0, cyc = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // target model
  logic [7:0] tgt_addr = 0;
  function automatic logic [7:0] tgt_byte(logic [7:0] a);
    case (a)
      8'd0: return 8'h1E;
      8'd1: return 8'h90;
      8'd2: return 8'h01;
      default: return a ^ 8'hA5;
    endcase
  endfunction
  assign data_in = !oe_n ? tgt_byte(tgt_addr) : 8'h00;

  int rdy_mode = 1; // 0 busy pulse, 1 always ready, 2 stuck busy
  int bcnt = 0;
  logic wr_prev_r = 1;
  always @(negedge clk) begin
    if (!wr_n && wr_prev_r && rdy_mode != 1) begin
      rdy <= 0;
      bcnt = (rdy_mode == 0) ? 10 : 0;
    end else if (bcnt > 0) begin
      bcnt--;
      if (bcnt == 0) rdy <= 1;
    end else if (rdy_mode == 1) rdy <= 1;
    wr_prev_r = wr_n;
  end

  // scoreboard queues: load {xa,bs,data}, response {chk_data,tmo,data}
  logic [10:0] load_q[$];
  logic [9:0]  rsp_q[$];
  int wr_exp = E_WR;
  logic bs_exp = 0;

  logic xt_prev = 0, wr_prev = 1, oe_prev = 1, oe_prev_m = 1, doe_prev = 0;
  logic [7:0] d_prev = 0;
  logic [1:0] xa_prev = 0;
  logic bs_prev = 0;
  int xh = 0, sc = 0, wl = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (!xtal1) begin
        if (data_oe && doe_prev && data_out == d_prev && xa == xa_prev && bs == bs_prev) sc++;
        else sc = data_oe ? 1 : 0;
      end
      if (xtal1 && !xt_prev) begin
        logic [10:0] e;
        chk(sc >= E_SETUP, "R2 setup cycles", sc, E_SETUP);
        if (load_q.size() == 0) chk(0, "R2 unexpected load", {xa, bs, data_out}, 0);
        else begin
          e = load_q.pop_front();
          chk({xa, bs, data_out} == e, "R2/R11 load word", {xa, bs, data_out}, e);
        end
        if (xa == XA_ADDR) tgt_addr = data_out;
      end
      if (xtal1) xh++;
      else if (xt_prev) begin
        chk(xh == E_XHI, "R3 xtal1 width", xh, E_XHI);
        xh = 0;
      end
      if (!wr_n) wl++;
      if (!wr_n && wr_prev) chk(bs == bs_exp, "R10 bs at wr fall", bs, bs_exp);
      if (wr_n && !wr_prev) begin
        chk(wl == wr_exp, "R6/R7 wr width", wl, wr_exp);
        wl = 0;
      end
      if (data_oe && (!oe_n || !oe_prev_m)) viol++;
      if (rsp_valid) begin
        logic [9:0] r;
        if (rsp_q.size() == 0) chk(0, "R12 unexpected rsp", 0, 0);
        else begin
          r = rsp_q.pop_front();
          chk(rsp_timeout == r[8], "R8/R9 timeout flag", rsp_timeout, r[8]);
          if (r[9]) chk(rsp_data == r[7:0], "R4/R11 read data", rsp_data, r[7:0]);
        end
        rsp_seen++;
      end
      xt_prev = xtal1; wr_prev = wr_n; oe_prev_m = oe_n; doe_prev = data_oe;
      d_prev = data_out; xa_prev = xa; bs_prev = bs;
      if (cyc > 100000) begin
        chk(0, "watchdog", cyc, 100000);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
    oe_prev = oe_n;
  end

  task automatic issue(logic [2:0] op, logic [7:0] d, logic b);
    int n0;
    n0 = rsp_seen;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_data = d; req_bs = b; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R12 busy after accept", req_ready, 0);
    wait (rsp_seen != n0);
    @(negedge clk);
    chk(req_ready, "R12 ready after rsp", req_ready, 1);
  endtask

  task automatic do_load(logic [2:0] op, logic [1:0] x, logic [7:0] d, logic b);
    load_q.push_back({x, b, d});
    rsp_q.push_back({1'b0, 1'b0, 8'h00});
    issue(op, d, b);
  endtask

  task automatic do_sig(logic [1:0] idx);
    load_q.push_back({XA_CMD, 1'b0, SIG_CMD});
    load_q.push_back({XA_ADDR, 1'b0, 6'd0, idx});
    rsp_q.push_back({1'b1, 1'b0, tgt_byte({6'd0, idx})});
    issue(OP_SIG, {6'd0, idx}, 1'b1);
  endtask

  task automatic do_write(bit long_w, int mode, logic b, bit exp_to);
    rdy_mode = mode;
    wr_exp = long_w ? E_LONG : E_WR;
    bs_exp = b;
    rsp_q.push_back({1'b0, exp_to, 8'h00});
    issue(long_w ? OP_WRITE_LONG : OP_WRITE, 8'h00, b);
    chk(bs == b, "R10 bs held to completion", bs, b);
  endtask

  initial begin
    #(CLK_NS * 3);
    chk(!xtal1 && wr_n && oe_n && !data_oe && !rsp_valid, "R1 reset outputs",
        {xtal1, wr_n, oe_n, data_oe, rsp_valid}, 5'b01100);
    chk(req_ready, "R1 ready in reset", req_ready, 1);
    @(negedge clk); rst_n = 1;
    do_load(OP_CMD,  XA_CMD,  8'h3C, 1'b0);   // R2
    do_load(OP_ADDR, XA_ADDR, 8'h01, 1'b1);   // R2
    do_load(OP_DATA, XA_DATA, 8'hA7, 1'b0);   // R2
    rsp_q.push_back({1'b1, 1'b0, 8'h90});      // R4 read at address 1
    issue(OP_READ, 8'h00, 1'b0);
    do_load(OP_ADDR, XA_ADDR, 8'h37, 1'b0);
    rsp_q.push_back({1'b1, 1'b0, 8'h37 ^ 8'hA5}); // R4 non-signature byte
    issue(OP_READ, 8'h00, 1'b1);
    do_sig(2'd0);                              // R11
    do_sig(2'd1);
    do_sig(2'd2);
    do_write(0, 0, 1'b1, 0);                   // R6 R8 busy pulse
    do_write(0, 1, 1'b0, 0);                   // R8 already ready
    do_write(1, 0, 1'b1, 0);                   // R7 long pulse
    do_write(0, 2, 1'b1, 1);                   // R9 timeout
    rdy_mode = 1;
    repeat (4) @(negedge clk);
    do_write(0, 1, 1'b0, 0);                   // R8 recovers after timeout
    chk(viol == 0, "R5 bus drive during OE", viol, 0);
    chk(load_q.size() == 0 && rsp_q.size() == 0, "R11 scoreboard drained",
        load_q.size() + rsp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule